// File: doc/BRIEF.md
# Pin I/O Controller with Per-Pin Interrupt Detection

This block is a register-mapped controller for up to 32 general-purpose pins. Software reaches it through a simple register port: an address, a write word, a write strobe and a read word that follows the address combinationally. Each pin has an input gate, an output-drive enable, an output value and an output inversion mask. The pad side is one input bit, one output bit and one output-enable bit per pin.

Each pin's input passes through a two-stage synchronizer. Four detectors then watch the synchronized value independently: rising edge, falling edge, held high and held low. Each detector has its own enable word and its own sticky pending word. A pending bit is cleared by writing a one to it. Every pin drives its own interrupt line. That line is high while any of the pin's four pending bits is set together with the matching enable bit.

The controller is a set of flat registers. The only sequencing it has is the synchronizer chain and the one-cycle history register used to find edges.

Top module: `pio_ctrl`

## Requirements
- R1: After reset every register is 0. Every mapped address reads 0, and `pad_oe`, `pad_out` and `pin_irq` are all 0.
- R2: The word offsets are: pin value 0x00, input enable 0x04, output enable 0x08, output value 0x0C, rise enable 0x18, rise pending 0x1C, fall enable 0x20, fall pending 0x24, high enable 0x28, high pending 0x2C, low enable 0x30, low pending 0x34, output invert 0x40. Bit n of each word belongs to pin n. Bits at or above NPINS read 0.
- R3: The pin value word returns the synchronized pad input ANDed with input enable. A pad change becomes readable two clock edges after it is applied. A pin whose input enable is 0 reads 0.
- R4: A rising edge sets the rise pending bit one edge after the new level becomes readable. A falling edge sets the fall pending bit in the same way.
- R5: The high pending bit is set on every cycle in which the readable pin value is 1, and the low pending bit on every cycle in which an enabled pin reads 0. If a clear and a set meet in the same cycle, the set wins, so a level that is still present reads back as pending right after its clear.
- R6: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged. Pending bits stay set until they are cleared.
- R7: Pending bits are set whether or not their detector is enabled. A pin whose input enable is 0 sets no pending bit.
- R8: `pin_irq[n]` is the OR, over the four detectors, of pending[n] AND enable[n]. It does not depend on any other pin.
- R9: When all four enable words are 0, every `pin_irq` bit is 0, whatever the pending bits hold.
- R10: `pad_oe` equals the output enable word. `pad_out[n]` equals output value XOR output invert while `pad_oe[n]` is 1, and is 0 otherwise.
- R11: Reads from unmapped offsets (including 0x10, 0x14, 0x38, 0x3C, 0x44 and non-word-aligned addresses) return 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 7 | Register byte address |
| bus_wdata | input | 32 | Write word |
| bus_we | input | 1 | Write strobe; the write takes effect at the clock edge |
| bus_rdata | output | 32 | Read word for `bus_addr` (combinational) |
| pad_in | input | NPINS | Asynchronous pin inputs |
| pad_out | output | NPINS | Pin output values |
| pad_oe | output | NPINS | Pin output-drive enables |
| pin_irq | output | NPINS | One interrupt line per pin |

## Verification
The bench builds the controller with NPINS = 12. With that width, every all-ones write shows whether bits 12 to 31 stay at zero when read back. Twelve pins are enough to set level-high and level-low pending bits on different pins at the same time, and to confirm that an interrupt appears only on the pin whose enable and pending bits meet. The synchronizer depth stays at its default of two, so the bench can check the two-edge input latency and the third-edge edge detection cycle by cycle.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int unsigned REG_W  = 32;
    localparam int unsigned ADDR_W = 7;
    localparam int unsigned NCOND  = 4;
    localparam int unsigned NCTL   = 4;

    // detector indexes
    localparam int unsigned COND_RISE = 0;
    localparam int unsigned COND_FALL = 1;
    localparam int unsigned COND_HIGH = 2;
    localparam int unsigned COND_LOW  = 3;

    // control register indexes
    localparam int unsigned CTL_IN_EN   = 0;
    localparam int unsigned CTL_OUT_EN  = 1;
    localparam int unsigned CTL_OUT_VAL = 2;
    localparam int unsigned CTL_OUT_INV = 3;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_PIN_VAL,
        SEL_IN_EN,
        SEL_OUT_EN,
        SEL_OUT_VAL,
        SEL_OUT_INV,
        SEL_RISE_EN,
        SEL_RISE_PND,
        SEL_FALL_EN,
        SEL_FALL_PND,
        SEL_HIGH_EN,
        SEL_HIGH_PND,
        SEL_LOW_EN,
        SEL_LOW_PND
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            7'h00:   s = SEL_PIN_VAL;
            7'h04:   s = SEL_IN_EN;
            7'h08:   s = SEL_OUT_EN;
            7'h0C:   s = SEL_OUT_VAL;
            7'h18:   s = SEL_RISE_EN;
            7'h1C:   s = SEL_RISE_PND;
            7'h20:   s = SEL_FALL_EN;
            7'h24:   s = SEL_FALL_PND;
            7'h28:   s = SEL_HIGH_EN;
            7'h2C:   s = SEL_HIGH_PND;
            7'h30:   s = SEL_LOW_EN;
            7'h34:   s = SEL_LOW_PND;
            7'h40:   s = SEL_OUT_INV;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic reg_sel_e ctl_sel(input int unsigned i);
        reg_sel_e s;
        case (i)
            CTL_IN_EN:   s = SEL_IN_EN;
            CTL_OUT_EN:  s = SEL_OUT_EN;
            CTL_OUT_VAL: s = SEL_OUT_VAL;
            default:     s = SEL_OUT_INV;
        endcase
        return s;
    endfunction

    function automatic reg_sel_e cond_en_sel(input int unsigned c);
        reg_sel_e s;
        case (c)
            COND_RISE: s = SEL_RISE_EN;
            COND_FALL: s = SEL_FALL_EN;
            COND_HIGH: s = SEL_HIGH_EN;
            default:   s = SEL_LOW_EN;
        endcase
        return s;
    endfunction

    function automatic reg_sel_e cond_pnd_sel(input int unsigned c);
        reg_sel_e s;
        case (c)
            COND_RISE: s = SEL_RISE_PND;
            COND_FALL: s = SEL_FALL_PND;
            COND_HIGH: s = SEL_HIGH_PND;
            default:   s = SEL_LOW_PND;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            for (int s = STAGES - 1; s > 0; s--) begin
                chain_q[s] <= chain_q[s-1];
            end
            chain_q[0] <= d;
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/pio_port_regs.sv
module pio_port_regs
    import pio_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCTL-1:0]  wr_stb,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] in_en,
    output logic [NPINS-1:0] out_en,
    output logic [NPINS-1:0] out_val,
    output logic [NPINS-1:0] out_inv,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);

    logic [NCTL-1:0][NPINS-1:0] ctl_q;

    for (genvar i = 0; i < NCTL; i++) begin : g_ctl
        logic [NPINS-1:0] r_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r_q <= '0;
            end else if (wr_stb[i]) begin
                r_q <= wdata;
            end
        end
        assign ctl_q[i] = r_q;
    end

    assign in_en   = ctl_q[CTL_IN_EN];
    assign out_en  = ctl_q[CTL_OUT_EN];
    assign out_val = ctl_q[CTL_OUT_VAL];
    assign out_inv = ctl_q[CTL_OUT_INV];

    // drive value only where the output driver is on
    always_comb begin
        pad_oe  = out_en;
        pad_out = (out_val ^ out_inv) & out_en;
    end

endmodule

// File: rtl/pio_cond_bank.sv
module pio_cond_bank
    import pio_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPINS-1:0]             pin_s,
    input  logic [NPINS-1:0]             pin_ien,
    input  logic [NCOND-1:0]             en_wr,
    input  logic [NCOND-1:0]             pnd_wr,
    input  logic [NPINS-1:0]             wdata,
    output logic [NCOND-1:0][NPINS-1:0]  en_q,
    output logic [NCOND-1:0][NPINS-1:0]  pnd_q,
    output logic [NPINS-1:0]             irq
);

    logic [NPINS-1:0]            prev_q;
    logic [NCOND-1:0][NPINS-1:0] hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= pin_s;
        end
    end

    always_comb begin
        hit[COND_RISE] =  pin_s & ~prev_q & pin_ien;
        hit[COND_FALL] = ~pin_s &  prev_q & pin_ien;
        hit[COND_HIGH] =  pin_s & pin_ien;
        hit[COND_LOW]  = ~pin_s & pin_ien;
    end

    for (genvar c = 0; c < NCOND; c++) begin : g_cond
        logic [NPINS-1:0] en_r;
        logic [NPINS-1:0] pnd_r;
        logic [NPINS-1:0] clr;

        assign clr = pnd_wr[c] ? wdata : '0;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_r <= '0;
            end else if (en_wr[c]) begin
                en_r <= wdata;
            end
        end

        // set has priority over a simultaneous clear
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pnd_r <= '0;
            end else begin
                pnd_r <= (pnd_r & ~clr) | hit[c];
            end
        end

        assign en_q[c]  = en_r;
        assign pnd_q[c] = pnd_r;
    end

    always_comb begin
        irq = '0;
        for (int c = 0; c < NCOND; c++) begin
            irq = irq | (en_q[c] & pnd_q[c]);
        end
    end

endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
    import pio_pkg::*;
#(
    parameter int unsigned NPINS       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [REG_W-1:0]    bus_wdata,
    input  logic                bus_we,
    output logic [REG_W-1:0]    bus_rdata,
    input  logic [NPINS-1:0]    pad_in,
    output logic [NPINS-1:0]    pad_out,
    output logic [NPINS-1:0]    pad_oe,
    output logic [NPINS-1:0]    pin_irq
);

    reg_sel_e                    sel;
    logic [NPINS-1:0]            wdata_n;
    logic [NPINS-1:0]            pin_s;
    logic [NPINS-1:0]            in_en;
    logic [NPINS-1:0]            out_en;
    logic [NPINS-1:0]            out_val;
    logic [NPINS-1:0]            out_inv;
    logic [NCTL-1:0]             ctl_wr;
    logic [NCOND-1:0]            cond_en_wr;
    logic [NCOND-1:0]            cond_pnd_wr;
    logic [NCOND-1:0][NPINS-1:0] cond_en;
    logic [NCOND-1:0][NPINS-1:0] cond_pnd;
    logic [NPINS-1:0]            rd_bits;

    assign sel     = decode_addr(bus_addr);
    assign wdata_n = bus_wdata[NPINS-1:0];

    for (genvar i = 0; i < NCTL; i++) begin : g_ctl_wr
        assign ctl_wr[i] = bus_we && (sel == ctl_sel(i));
    end

    for (genvar c = 0; c < NCOND; c++) begin : g_cond_wr
        assign cond_en_wr[c]  = bus_we && (sel == cond_en_sel(c));
        assign cond_pnd_wr[c] = bus_we && (sel == cond_pnd_sel(c));
    end

    pio_sync #(
        .W      (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_s)
    );

    pio_port_regs #(
        .NPINS (NPINS)
    ) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (ctl_wr),
        .wdata   (wdata_n),
        .in_en   (in_en),
        .out_en  (out_en),
        .out_val (out_val),
        .out_inv (out_inv),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    pio_cond_bank #(
        .NPINS (NPINS)
    ) u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_s   (pin_s),
        .pin_ien (in_en),
        .en_wr   (cond_en_wr),
        .pnd_wr  (cond_pnd_wr),
        .wdata   (wdata_n),
        .en_q    (cond_en),
        .pnd_q   (cond_pnd),
        .irq     (pin_irq)
    );

    always_comb begin
        rd_bits = '0;
        unique case (sel)
            SEL_NONE:     rd_bits = '0;
            SEL_PIN_VAL:  rd_bits = pin_s & in_en;
            SEL_IN_EN:    rd_bits = in_en;
            SEL_OUT_EN:   rd_bits = out_en;
            SEL_OUT_VAL:  rd_bits = out_val;
            SEL_OUT_INV:  rd_bits = out_inv;
            SEL_RISE_EN:  rd_bits = cond_en[COND_RISE];
            SEL_RISE_PND: rd_bits = cond_pnd[COND_RISE];
            SEL_FALL_EN:  rd_bits = cond_en[COND_FALL];
            SEL_FALL_PND: rd_bits = cond_pnd[COND_FALL];
            SEL_HIGH_EN:  rd_bits = cond_en[COND_HIGH];
            SEL_HIGH_PND: rd_bits = cond_pnd[COND_HIGH];
            SEL_LOW_EN:   rd_bits = cond_en[COND_LOW];
            SEL_LOW_PND:  rd_bits = cond_pnd[COND_LOW];
        endcase
        bus_rdata = REG_W'(rd_bits);
    end

endmodule

// File: rtl/pio_ctrl_chk.sv
module pio_ctrl_chk
    import pio_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         bus_we,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic [NPINS-1:0]             wdata_n,
    input logic [NPINS-1:0]             pad_out,
    input logic [NPINS-1:0]             pad_oe,
    input logic [NPINS-1:0]             pin_irq,
    input logic [NPINS-1:0]             in_en,
    input logic [NCOND-1:0][NPINS-1:0]  cond_en,
    input logic [NCOND-1:0][NPINS-1:0]  cond_pnd
);

    logic [NPINS-1:0] rise_clr;
    assign rise_clr = (bus_we && bus_addr == 7'h1C) ? wdata_n : '0;

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~cond_pnd[COND_RISE] & $past(cond_pnd[COND_RISE] & ~rise_clr)) == '0)); // R6

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_en == '0) |-> (pin_irq == '0)); // R9

    AST_OUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & ~pad_oe) == '0)); // R10

    AST_NO_DETECT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cond_pnd[COND_HIGH] & ~$past(cond_pnd[COND_HIGH]) & ~$past(in_en)) == '0)); // R7

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_irq & ~(cond_pnd[COND_RISE] | cond_pnd[COND_FALL]
                      | cond_pnd[COND_HIGH] | cond_pnd[COND_LOW])) == '0)); // R8

endmodule

bind pio_ctrl pio_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .wdata_n  (wdata_n),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .pin_irq  (pin_irq),
    .in_en    (in_en),
    .cond_en  (cond_en),
    .cond_pnd (cond_pnd)
);

// File: tb/test_pio_ctrl.sv
`timescale 1ns/100ps
module test_pio_ctrl;

    localparam int unsigned NP = 12;
    localparam logic [31:0] MASK = 32'h0000_0FFF;

    localparam logic [6:0] A_PIN  = 7'h00, A_IEN  = 7'h04, A_OEN  = 7'h08, A_OVAL = 7'h0C;
    localparam logic [6:0] A_REN  = 7'h18, A_RPND = 7'h1C, A_FEN  = 7'h20, A_FPND = 7'h24;
    localparam logic [6:0] A_HEN  = 7'h28, A_HPND = 7'h2C, A_LEN  = 7'h30, A_LPND = 7'h34;
    localparam logic [6:0] A_OINV = 7'h40;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [6:0]    bus_addr;
    logic [31:0]   bus_wdata;
    logic          bus_we;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic [NP-1:0] pin_irq;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    pio_ctrl #(.NPINS(NP)) i_pio_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pin_irq   (pin_irq)
    );

    function automatic logic [31:0] exp_pad(input logic [31:0] v, input logic [31:0] inv,
                                            input logic [31:0] oe);
        return (v ^ inv) & oe & MASK;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_addr  = A_PIN;
    endtask

    task automatic rd_chk(input string tag, input logic [6:0] a, input logic [31:0] exp);
        bus_addr = a;
        #0.2;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [6:0] all_addr [13];
        logic [6:0] bad_addr [5];
        logic [31:0] rv, ri, ro, re;
        int unsigned seed_set;
        all_addr = '{A_PIN, A_IEN, A_OEN, A_OVAL, A_REN, A_RPND, A_FEN, A_FPND,
                     A_HEN, A_HPND, A_LEN, A_LPND, A_OINV};
        bad_addr = '{7'h10, 7'h14, 7'h38, 7'h44, 7'h05};
        rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; pad_in = '0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        for (int i = 0; i < 13; i++) rd_chk("R1 reset read", all_addr[i], 32'h0);
        chk("R1 reset pin_irq", 32'(pin_irq), 32'h0);
        chk("R1 reset pad_oe", 32'(pad_oe), 32'h0);
        chk("R1 reset pad_out", 32'(pad_out), 32'h0);

        // R3 / R7 input gated off
        pad_in = 12'h005;
        wait_cyc(5);
        rd_chk("R3 gated pin value", A_PIN, 32'h0);
        rd_chk("R7 gated high pending", A_HPND, 32'h0);
        rd_chk("R7 gated low pending", A_LPND, 32'h0);

        // R2 upper bits read zero
        wr(A_IEN, 32'hFFFF_FFFF);
        rd_chk("R2 input enable masked", A_IEN, MASK);
        wait_cyc(3);
        rd_chk("R3 pin value", A_PIN, 32'h005);
        rd_chk("R5 high pending", A_HPND, 32'h005);
        rd_chk("R5 low pending", A_LPND, 32'hFFA);
        rd_chk("R4 no rise without edge", A_RPND, 32'h0);
        chk("R7 pending without enable no irq", 32'(pin_irq), 32'h0);

        // R3 latency and R4 rise timing
        pad_in = 12'h00D;
        wait_cyc(1);
        rd_chk("R3 after one edge", A_PIN, 32'h005);
        wait_cyc(1);
        rd_chk("R3 after two edges", A_PIN, 32'h00D);
        rd_chk("R4 rise not yet", A_RPND, 32'h0);
        wait_cyc(1);
        rd_chk("R4 rise pending", A_RPND, 32'h008);
        rd_chk("R6 low pending sticky", A_LPND, 32'hFFA);

        // R8 per-pin irq
        wr(A_REN, 32'h008);
        chk("R8 irq on pin 3 only", 32'(pin_irq), 32'h008);

        // R6 write-zero and write-one
        wr(A_RPND, 32'h0);
        rd_chk("R6 write zero keeps", A_RPND, 32'h008);
        wr(A_RPND, 32'h008);
        rd_chk("R6 write one clears", A_RPND, 32'h0);
        chk("R8 irq drops after clear", 32'(pin_irq), 32'h0);

        // R5 set wins over clear
        wr(A_HPND, 32'h00D);
        rd_chk("R5 high re-set after clear", A_HPND, 32'h00D);
        wr(A_LPND, 32'hFFF);
        rd_chk("R5 low re-set after clear", A_LPND, 32'hFF2);

        // R4 fall
        pad_in = 12'h005;
        wait_cyc(4);
        rd_chk("R4 fall pending", A_FPND, 32'h008);
        rd_chk("R6 high pending sticky", A_HPND, 32'h00D);

        // R9 masking
        wr(A_FEN, 32'hFFF);
        wr(A_HEN, 32'hFFF);
        wr(A_LEN, 32'hFFF);
        chk("R8 all enables irq", 32'(pin_irq), 32'hFFF);
        wr(A_REN, 32'h0);
        wr(A_FEN, 32'h0);
        wr(A_HEN, 32'h0);
        wr(A_LEN, 32'h0);
        chk("R9 irq masked", 32'(pin_irq), 32'h0);
        rd_chk("R9 pending kept", A_FPND, 32'h008);

        // R11 unmapped
        for (int i = 0; i < 5; i++) begin
            wr(bad_addr[i], 32'hFFFF_FFFF);
            rd_chk("R11 unmapped read", bad_addr[i], 32'h0);
        end
        rd_chk("R11 out enable untouched", A_OEN, 32'h0);
        rd_chk("R11 input enable untouched", A_IEN, MASK);
        rd_chk("R11 rise enable untouched", A_REN, 32'h0);
        chk("R11 pad_oe untouched", 32'(pad_oe), 32'h0);

        // R7 no detection while gated
        wr(A_IEN, 32'h0);
        wr(A_RPND, 32'hFFF); wr(A_FPND, 32'hFFF); wr(A_HPND, 32'hFFF); wr(A_LPND, 32'hFFF);
        pad_in = 12'hA5A;
        wait_cyc(4);
        pad_in = 12'h000;
        wait_cyc(4);
        rd_chk("R7 rise gated", A_RPND, 32'h0);
        rd_chk("R7 fall gated", A_FPND, 32'h0);
        rd_chk("R7 high gated", A_HPND, 32'h0);
        rd_chk("R7 low gated", A_LPND, 32'h0);
        rd_chk("R3 gated read zero", A_PIN, 32'h0);

        // R10 directed
        wr(A_OVAL, 32'h0F0);
        wr(A_OINV, 32'h0FF);
        wr(A_OEN, 32'h00F);
        chk("R10 pad_out directed", 32'(pad_out), exp_pad(32'h0F0, 32'h0FF, 32'h00F));
        chk("R10 pad_oe directed", 32'(pad_oe), 32'h00F);

        // R10 / R2 random
        seed_set = $urandom(32'h1357);
        for (int k = 0; k < 40; k++) begin
            rv = $urandom; ri = $urandom; ro = $urandom; re = $urandom;
            wr(A_OVAL, rv);
            wr(A_OINV, ri);
            wr(A_OEN, ro);
            chk("R10 pad_out random", 32'(pad_out), exp_pad(rv, ri, ro));
            chk("R10 pad_oe random", 32'(pad_oe), ro & MASK);
            rd_chk("R2 output invert readback", A_OINV, ri & MASK);
            wr(A_HEN, re);
            rd_chk("R2 high enable readback", A_HEN, re & MASK);
        end
        wr(A_HEN, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule